// File: doc/BRIEF.md
# Breakpoint Value Match Unit

This block keeps a bank of breakpoint value registers, each paired with a small control register that holds an enable bit and a 4-bit type code. Every cycle it compares the running execution context against every implemented breakpoint in parallel. The context is made of the program counter, the two context identifiers for the guest and hypervisor levels, the current virtual machine identifier, the exception level and the virtualization mode bits. For each breakpoint it then raises one registered match bit.

The type code selects how the 64-bit value is interpreted. It can be an instruction address, a context identifier chosen by the virtualization mode, a fixed-level context identifier, a VMID, a VMID with a context identifier, or a pair of context identifiers. Feature inputs widen the compared address field and the VMID field. A simple write port loads values and controls. A combinational read port returns each value with the fields that the current type leaves unused forced to zero.

Top module: `bpv_match_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every match bit is 0, and every value and control register reads as zero.
- R2: A match bit reflects the context inputs and register contents sampled at one rising clock edge and is visible only after that edge. A breakpoint whose enable (control bit 0) is 0 never matches.
- R3: With kind 000 (type bits [3:1]), the address compare uses value bits [48:2] against the PC. PC bits [1:0] are ignored, and value bits [1:0] read as zero.
- R4: With `lva_en` set, value bits [52:49] are also compared. With `lva3_en` set, bits [56:49] are compared. Otherwise those bits and bits [63:57] take no part in the compare.
- R5: Kind 001 compares value bits [31:0] with `cid_el2` when `e2h` is 1 and either `cur_el` is 2, or `tge` is 1 with `cur_el` 0 and `el2_en` 1. In all other cases it compares with `cid_el1`.
- R6: Kinds 011 and 101 compare bits [31:0] with `cid_el1`. Kinds 110 and 111 compare bits [63:32] with `cid_el2`, and kind 111 also compares bits [31:0] with `cid_el1`. Kind 101 also needs a VMID hit. A combined kind matches only when every part is equal.
- R7: The VMID in bits [39:32] is 8 bits wide. It becomes 16 bits (bits [47:32]) only when both `vmid16_en` and `el2_is64` are 1.
- R8: Kind 010 is reserved. It never matches, and its value reads as zero.
- R9: A value read (`rd_ctl`=0) is masked by the current kind as follows. Context kinds 001 and 011 return bits [31:0]. Kind 100 returns the VMID field only. Kind 101 returns the VMID field and bits [31:0]. Kind 110 returns bits [63:32]. Kind 111 returns all bits. A control read returns {type, enable} in bits [4:0] with zero above.
- R10: An index at or above NUM_BP is unimplemented. A write to it changes no register, and a read of it returns zero.
- R11: Type bit 0 has no effect on the compare.
- R12: Each match bit depends only on its own breakpoint's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ctl | input | 1 | 1: write control register, 0: write value register |
| wr_idx | input | IDX_W | Breakpoint index for the write |
| wr_data | input | 64 | Write data (control: bit 0 enable, bits [4:1] type) |
| rd_ctl | input | 1 | 1: read control register, 0: read value register |
| rd_idx | input | IDX_W | Breakpoint index for the read |
| rd_data | output | 64 | Combinational read data |
| pc | input | 64 | Current instruction address |
| cid_el1 | input | 32 | Guest-level context identifier |
| cid_el2 | input | 32 | Hypervisor-level context identifier |
| vmid | input | 16 | Current virtual machine identifier |
| cur_el | input | 2 | Current exception level |
| e2h | input | 1 | Host-kernel-at-hypervisor mode bit |
| tge | input | 1 | Trap-general-exceptions mode bit |
| el2_en | input | 1 | Hypervisor level enabled in the current security state |
| lva_en | input | 1 | 52-bit address option |
| lva3_en | input | 1 | 56-bit address option |
| vmid16_en | input | 1 | 16-bit VMID mode |
| el2_is64 | input | 1 | Hypervisor level runs in 64-bit state |
| match_o | output | NUM_BP | Registered per-breakpoint match |

## Verification
Read data is combinational, so the bench checks it a nanosecond after driving the index at a falling edge. A register write takes effect at the rising edge that samples `wr_en`. A match bit is due one rising edge after its context inputs are driven. The bench therefore drives inputs at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. A separate check samples just before that edge to confirm the bit has not appeared early.

// File: rtl/bpv_pkg.sv
package bpv_pkg;

    localparam int VAL_W   = 64;
    localparam int TYPE_W  = 4;
    localparam int CID_W   = 32;
    localparam int VMID_W  = 16;
    localparam int VA_BASE = 48;
    localparam int VA_LVA  = 52;
    localparam int VA_LVA3 = 56;

    // interpretation selected by type bits [3:1]
    typedef enum logic [2:0] {
        BK_ADDR     = 3'b000,
        BK_CTX_AUTO = 3'b001,
        BK_RSVD     = 3'b010,
        BK_CTX_EL1  = 3'b011,
        BK_VMID     = 3'b100,
        BK_VMID_CTX = 3'b101,
        BK_CTX_EL2  = 3'b110,
        BK_CTX_PAIR = 3'b111
    } bp_kind_e;

    function automatic bp_kind_e kind_of(input logic [TYPE_W-1:0] typ);
        return bp_kind_e'(typ[TYPE_W-1:1]);
    endfunction

    // bits of the value register that are meaningful for a kind
    function automatic logic [VAL_W-1:0] view_mask(input bp_kind_e k, input logic v16);
        logic [VAL_W-1:0] vm_f;
        logic [VAL_W-1:0] m;
        vm_f = v16 ? 64'h0000_FFFF_0000_0000 : 64'h0000_00FF_0000_0000;
        unique case (k)
            BK_ADDR:     m = 64'hFFFF_FFFF_FFFF_FFFC;
            BK_CTX_AUTO: m = 64'h0000_0000_FFFF_FFFF;
            BK_CTX_EL1:  m = 64'h0000_0000_FFFF_FFFF;
            BK_VMID:     m = vm_f;
            BK_VMID_CTX: m = vm_f | 64'h0000_0000_FFFF_FFFF;
            BK_CTX_EL2:  m = 64'hFFFF_FFFF_0000_0000;
            BK_CTX_PAIR: m = '1;
            default:     m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bpv_ctx_sel.sv
module bpv_ctx_sel
    import bpv_pkg::*;
(
    input  logic [1:0]       cur_el,
    input  logic             e2h,
    input  logic             tge,
    input  logic             el2_en,
    input  logic [CID_W-1:0] cid_el1,
    input  logic [CID_W-1:0] cid_el2,
    input  logic             lva_en,
    input  logic             lva3_en,
    input  logic             vmid16_en,
    input  logic             el2_is64,
    output logic [CID_W-1:0] auto_cid,
    output logic [VAL_W-1:0] addr_mask,
    output logic             vmid16_act
);

    logic use_el2;
    int   va_top;

    always_comb begin
        use_el2 = e2h && ((cur_el == 2'd2) || (tge && el2_en && (cur_el == 2'd0)));
        auto_cid = use_el2 ? cid_el2 : cid_el1;
    end

    always_comb begin
        if (lva3_en)     va_top = VA_LVA3;
        else if (lva_en) va_top = VA_LVA;
        else             va_top = VA_BASE;
        for (int i = 0; i < VAL_W; i++) begin
            addr_mask[i] = (i >= 2) && (i <= va_top);
        end
    end

    assign vmid16_act = vmid16_en & el2_is64;

endmodule

// File: rtl/bpv_regbank.sv
module bpv_regbank
    import bpv_pkg::*;
#(
    parameter int NUM_BP = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctl,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VAL_W-1:0]  wr_data,
    input  logic              rd_ctl,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              vmid16_act,
    output logic [VAL_W-1:0]  rd_data,
    output bp_kind_e          rd_kind,
    output logic [VAL_W-1:0]  val_o  [NUM_BP],
    output bp_kind_e          kind_o [NUM_BP],
    output logic [NUM_BP-1:0] en_o
);

    localparam int SEL_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;

    logic [VAL_W-1:0]  val_q [NUM_BP];
    logic [TYPE_W-1:0] typ_q [NUM_BP];
    logic [NUM_BP-1:0] en_q;

    logic             wr_ok;
    logic             rd_ok;
    logic [SEL_W-1:0] wsel;
    logic [SEL_W-1:0] rsel;

    assign wr_ok = ({1'b0, wr_idx} < (IDX_W+1)'(NUM_BP));
    assign rd_ok = ({1'b0, rd_idx} < (IDX_W+1)'(NUM_BP));
    assign wsel  = wr_idx[SEL_W-1:0];
    assign rsel  = rd_idx[SEL_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BP; b++) begin
                val_q[b] <= '0;
                typ_q[b] <= '0;
            end
            en_q <= '0;
        end else if (wr_en && wr_ok) begin
            if (wr_ctl) begin
                typ_q[wsel] <= wr_data[TYPE_W:1];
                en_q[wsel]  <= wr_data[0];
            end else begin
                val_q[wsel] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_kind = rd_ok ? kind_of(typ_q[rsel]) : BK_RSVD;
        if (!rd_ok)
            rd_data = '0;
        else if (rd_ctl)
            rd_data = {{(VAL_W-TYPE_W-1){1'b0}}, typ_q[rsel], en_q[rsel]};
        else
            rd_data = val_q[rsel] & view_mask(rd_kind, vmid16_act);
    end

    generate
        for (genvar g = 0; g < NUM_BP; g++) begin : g_out
            assign val_o[g]  = val_q[g];
            assign kind_o[g] = kind_of(typ_q[g]);
        end
    endgenerate

    assign en_o = en_q;

endmodule

// File: rtl/bpv_cmp.sv
module bpv_cmp
    import bpv_pkg::*;
(
    input  logic [VAL_W-1:0]  val,
    input  bp_kind_e          kind,
    input  logic              en,
    input  logic [VAL_W-1:0]  pc,
    input  logic [VAL_W-1:0]  addr_mask,
    input  logic [CID_W-1:0]  cid_el1,
    input  logic [CID_W-1:0]  cid_el2,
    input  logic [CID_W-1:0]  auto_cid,
    input  logic [VMID_W-1:0] vmid,
    input  logic              vmid16_act,
    output logic              hit
);

    logic addr_eq;
    logic lo_el1_eq;
    logic lo_auto_eq;
    logic hi_el2_eq;
    logic vmid_eq;
    logic raw;

    always_comb begin
        addr_eq    = ((val ^ pc) & addr_mask) == '0;
        lo_el1_eq  = val[CID_W-1:0] == cid_el1;
        lo_auto_eq = val[CID_W-1:0] == auto_cid;
        hi_el2_eq  = val[VAL_W-1:CID_W] == cid_el2;
        vmid_eq    = vmid16_act ? (val[CID_W+VMID_W-1:CID_W] == vmid)
                                : (val[CID_W+7:CID_W] == vmid[7:0]);
    end

    always_comb begin
        unique case (kind)
            BK_ADDR:     raw = addr_eq;
            BK_CTX_AUTO: raw = lo_auto_eq;
            BK_CTX_EL1:  raw = lo_el1_eq;
            BK_VMID:     raw = vmid_eq;
            BK_VMID_CTX: raw = vmid_eq & lo_el1_eq;
            BK_CTX_EL2:  raw = hi_el2_eq;
            BK_CTX_PAIR: raw = hi_el2_eq & lo_el1_eq;
            default:     raw = 1'b0;
        endcase
    end

    assign hit = en & raw;

endmodule

// File: rtl/bpv_match_unit.sv
module bpv_match_unit
    import bpv_pkg::*;
#(
    parameter int NUM_BP = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctl,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [63:0]       wr_data,
    input  logic              rd_ctl,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [63:0]       rd_data,
    input  logic [63:0]       pc,
    input  logic [31:0]       cid_el1,
    input  logic [31:0]       cid_el2,
    input  logic [15:0]       vmid,
    input  logic [1:0]        cur_el,
    input  logic              e2h,
    input  logic              tge,
    input  logic              el2_en,
    input  logic              lva_en,
    input  logic              lva3_en,
    input  logic              vmid16_en,
    input  logic              el2_is64,
    output logic [NUM_BP-1:0] match_o
);

    logic [CID_W-1:0]  auto_cid;
    logic [VAL_W-1:0]  addr_mask;
    logic              vmid16_act;
    bp_kind_e          rd_kind;
    logic [VAL_W-1:0]  val_arr  [NUM_BP];
    bp_kind_e          kind_arr [NUM_BP];
    logic [NUM_BP-1:0] en_vec;
    logic [NUM_BP-1:0] rsvd_vec;
    logic [NUM_BP-1:0] hit_vec;
    logic [NUM_BP-1:0] match_q;

    bpv_ctx_sel u_ctx (
        .cur_el     (cur_el),
        .e2h        (e2h),
        .tge        (tge),
        .el2_en     (el2_en),
        .cid_el1    (cid_el1),
        .cid_el2    (cid_el2),
        .lva_en     (lva_en),
        .lva3_en    (lva3_en),
        .vmid16_en  (vmid16_en),
        .el2_is64   (el2_is64),
        .auto_cid   (auto_cid),
        .addr_mask  (addr_mask),
        .vmid16_act (vmid16_act)
    );

    bpv_regbank #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_ctl     (wr_ctl),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_ctl     (rd_ctl),
        .rd_idx     (rd_idx),
        .vmid16_act (vmid16_act),
        .rd_data    (rd_data),
        .rd_kind    (rd_kind),
        .val_o      (val_arr),
        .kind_o     (kind_arr),
        .en_o       (en_vec)
    );

    generate
        for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
            bpv_cmp u_cmp (
                .val        (val_arr[g]),
                .kind       (kind_arr[g]),
                .en         (en_vec[g]),
                .pc         (pc),
                .addr_mask  (addr_mask),
                .cid_el1    (cid_el1),
                .cid_el2    (cid_el2),
                .auto_cid   (auto_cid),
                .vmid       (vmid),
                .vmid16_act (vmid16_act),
                .hit        (hit_vec[g])
            );
            assign rsvd_vec[g] = (kind_arr[g] == BK_RSVD);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= hit_vec;
    end

    assign match_o = match_q;

endmodule

// File: rtl/bpv_match_unit_chk.sv
module bpv_match_unit_chk
    import bpv_pkg::*;
#(
    parameter int NUM_BP = 16,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_BP-1:0] match_o,
    input logic [NUM_BP-1:0] en_vec,
    input logic [NUM_BP-1:0] rsvd_vec,
    input logic              rd_ctl,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [63:0]       rd_data,
    input bp_kind_e          rd_kind
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> match_o == '0);

    // R2
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o & ~$past(en_vec)) == '0);

    // R8
    reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o & $past(rsvd_vec)) == '0);

    // R10
    unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_idx} >= (IDX_W+1)'(NUM_BP)) |-> rd_data == '0);

    // R3
    addr_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ctl && rd_kind == BK_ADDR) |-> rd_data[1:0] == 2'b00);

endmodule

bind bpv_match_unit bpv_match_unit_chk #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .match_o  (match_o),
    .en_vec   (en_vec),
    .rsvd_vec (rsvd_vec),
    .rd_ctl   (rd_ctl),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rd_kind  (rd_kind)
);

// File: tb/test_bpv_match_unit.sv
module test_bpv_match_unit;

    localparam int NUM_BP = 16;
    localparam int IDX_W  = 6;

    typedef struct packed {
        logic [3:0]  typ;
        logic [63:0] val;
        logic [63:0] pc;
        logic [31:0] c1;
        logic [31:0] c2;
        logic [15:0] vm;
        logic [1:0]  el;
        logic        e2h;
        logic        tge;
        logic        el2en;
        logic        lva;
        logic        lva3;
        logic [1:0]  v16;   // {vmid16_en, el2_is64}
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        // R3 address compare
        '{4'h0, 64'h0000_0000_4000_1000, 64'h0000_0000_4000_1000, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd3},
        '{4'h0, 64'h0000_0000_4000_1000, 64'h0000_0000_4000_1003, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd3},
        '{4'h0, 64'h0000_0000_4000_1000, 64'h0000_0000_4000_1004, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'd3},
        // R4 address width options
        '{4'h0, 64'h0004_0000_4000_1000, 64'h0000_0000_4000_1000, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd4},
        '{4'h0, 64'h0004_0000_4000_1000, 64'h0000_0000_4000_1000, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 8'd4},
        '{4'h0, 64'h0040_0000_4000_1000, 64'h0000_0000_4000_1000, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 8'd4},
        '{4'h0, 64'h0040_0000_4000_1000, 64'h0000_0000_4000_1000, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 8'd4},
        // R5 context source selection
        '{4'h2, 64'h0000_0000_0000_AAAA, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd5},
        '{4'h2, 64'h0000_0000_0000_AAAA, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'd5},
        '{4'h2, 64'h0000_0000_0000_5555, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd5},
        '{4'h2, 64'h0000_0000_0000_5555, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8'd5},
        '{4'h2, 64'h0000_0000_0000_5555, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'd5},
        '{4'h2, 64'h0000_0000_0000_5555, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 8'd5},
        // R6 fixed-level and combined kinds
        '{4'h6, 64'h0000_0000_0000_AAAA, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd6},
        '{4'hC, 64'h0000_5555_1234_5678, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd6},
        '{4'hE, 64'h0000_5555_0000_AAAA, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd6},
        '{4'hE, 64'h0000_5555_0000_AAAA, 64'h0, 32'hAAAB, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'd6},
        '{4'hE, 64'h0000_5556_0000_AAAA, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'd6},
        // R7 VMID width
        '{4'h8, 64'h0000_3412_0000_0000, 64'h0, 32'hAAAA, 32'h5555, 16'h0012, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd7},
        '{4'h8, 64'h0000_3412_0000_0000, 64'h0, 32'hAAAA, 32'h5555, 16'h0012, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 8'd7},
        '{4'h8, 64'h0000_3412_0000_0000, 64'h0, 32'hAAAA, 32'h5555, 16'h3412, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 8'd7},
        '{4'h8, 64'h0000_3412_0000_0000, 64'h0, 32'hAAAA, 32'h5555, 16'h0012, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 8'd7},
        // R6 VMID plus context
        '{4'hA, 64'h0000_0012_0000_AAAA, 64'h0, 32'hAAAA, 32'h5555, 16'h0012, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd6},
        '{4'hA, 64'h0000_0012_0000_AAAA, 64'h0, 32'hAAAB, 32'h5555, 16'h0012, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'd6},
        // R8 reserved kind
        '{4'h4, 64'h0, 64'h0, 32'h0, 32'h0, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'd8},
        // R11 type bit 0 ignored
        '{4'h3, 64'h0000_0000_0000_AAAA, 64'h0, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd11},
        '{4'h1, 64'h0000_0000_4000_1000, 64'h0000_0000_4000_1000, 32'hAAAA, 32'h5555, 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'd11}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_ctl = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [63:0]       wr_data = '0;
    logic              rd_ctl = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [63:0]       rd_data;
    logic [63:0]       pc = '0;
    logic [31:0]       cid_el1 = '0;
    logic [31:0]       cid_el2 = '0;
    logic [15:0]       vmid = '0;
    logic [1:0]        cur_el = '0;
    logic              e2h = 1'b0;
    logic              tge = 1'b0;
    logic              el2_en = 1'b0;
    logic              lva_en = 1'b0;
    logic              lva3_en = 1'b0;
    logic              vmid16_en = 1'b0;
    logic              el2_is64 = 1'b0;
    logic [NUM_BP-1:0] match_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bpv_match_unit #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) i_bpv_match_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_ctl(rd_ctl), .rd_idx(rd_idx), .rd_data(rd_data),
        .pc(pc), .cid_el1(cid_el1), .cid_el2(cid_el2), .vmid(vmid), .cur_el(cur_el),
        .e2h(e2h), .tge(tge), .el2_en(el2_en), .lva_en(lva_en), .lva3_en(lva3_en),
        .vmid16_en(vmid16_en), .el2_is64(el2_is64), .match_o(match_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic ctl, input int idx, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ctl = ctl; wr_idx = IDX_W'(idx); wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic ctl, input int idx, output logic [63:0] d);
        @(negedge clk);
        rd_ctl = ctl; rd_idx = IDX_W'(idx);
        #1 d = rd_data;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] r;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "match in reset", 64'(match_o), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "match after release", 64'(match_o), 64'h0);
        read_reg(1'b0, 0, r);
        check("R1", "value after reset", r, 64'h0);
        read_reg(1'b1, 0, r);
        check("R1", "control after reset", r, 64'h0);

        for (int i = 0; i < NV; i++) begin
            write_reg(1'b0, 0, VECS[i].val);
            write_reg(1'b1, 0, {59'b0, VECS[i].typ, 1'b1});
            @(negedge clk);
            pc = VECS[i].pc; cid_el1 = VECS[i].c1; cid_el2 = VECS[i].c2;
            vmid = VECS[i].vm; cur_el = VECS[i].el; e2h = VECS[i].e2h;
            tge = VECS[i].tge; el2_en = VECS[i].el2en; lva_en = VECS[i].lva;
            lva3_en = VECS[i].lva3; vmid16_en = VECS[i].v16[1]; el2_is64 = VECS[i].v16[0];
            settle();
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i),
                  64'(match_o[0]), 64'(VECS[i].exp));
        end

        // R2 timing and enable gating
        e2h = 0; tge = 0; el2_en = 0; lva_en = 0; lva3_en = 0; vmid16_en = 0; el2_is64 = 0;
        write_reg(1'b0, 0, 64'h0000_0000_0000_8000);
        write_reg(1'b1, 0, 64'h1);
        @(negedge clk); pc = 64'h0;
        settle();
        check("R2", "mismatch baseline", 64'(match_o[0]), 64'h0);
        pc = 64'h8000;
        #1 check("R2", "not before edge", 64'(match_o[0]), 64'h0);
        settle();
        check("R2", "one edge later", 64'(match_o[0]), 64'h1);
        write_reg(1'b1, 0, 64'h0);
        settle();
        check("R2", "disabled", 64'(match_o), 64'h0);

        // R9 read masks per kind
        write_reg(1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        write_reg(1'b1, 0, 64'h0);
        read_reg(1'b0, 0, r); check("R3", "addr low bits read", r, 64'hFFFF_FFFF_FFFF_FFFC);
        write_reg(1'b1, 0, 64'h4);
        read_reg(1'b0, 0, r); check("R9", "ctx read", r, 64'h0000_0000_FFFF_FFFF);
        write_reg(1'b1, 0, 64'h10);
        read_reg(1'b0, 0, r); check("R9", "vmid8 read", r, 64'h0000_00FF_0000_0000);
        vmid16_en = 1; el2_is64 = 1;
        read_reg(1'b0, 0, r); check("R9", "vmid16 read", r, 64'h0000_FFFF_0000_0000);
        vmid16_en = 0; el2_is64 = 0;
        write_reg(1'b1, 0, 64'h14);
        read_reg(1'b0, 0, r); check("R9", "vmid+ctx read", r, 64'h0000_00FF_FFFF_FFFF);
        write_reg(1'b1, 0, 64'h18);
        read_reg(1'b0, 0, r); check("R9", "el2 ctx read", r, 64'hFFFF_FFFF_0000_0000);
        write_reg(1'b1, 0, 64'h1D);
        read_reg(1'b0, 0, r); check("R9", "pair read", r, 64'hFFFF_FFFF_FFFF_FFFF);
        read_reg(1'b1, 0, r); check("R9", "control read", r, 64'h1D);
        // R8 reserved kind reads zero
        write_reg(1'b1, 0, 64'h8);
        read_reg(1'b0, 0, r); check("R8", "reserved read", r, 64'h0);

        // R10 unimplemented index
        write_reg(1'b0, 4, 64'h0000_0000_1234_5678);
        write_reg(1'b1, 4, 64'h7);
        write_reg(1'b0, 20, 64'hDEAD_BEEF_0000_0000);
        write_reg(1'b1, 20, 64'h1F);
        read_reg(1'b0, 4, r); check("R10", "alias value kept", r, 64'h0000_0000_1234_5678);
        read_reg(1'b1, 4, r); check("R10", "alias control kept", r, 64'h7);
        read_reg(1'b0, 20, r); check("R10", "unimpl value read", r, 64'h0);
        read_reg(1'b1, 20, r); check("R10", "unimpl control read", r, 64'h0);
        write_reg(1'b1, 4, 64'h0);

        // R12 independence
        write_reg(1'b1, 0, 64'h1);
        write_reg(1'b0, 0, 64'h0000_0000_0000_2000);
        write_reg(1'b0, 1, 64'h0000_0000_0000_3000);
        write_reg(1'b1, 1, 64'h1);
        @(negedge clk); pc = 64'h3000;
        settle();
        check("R12", "only bp1", 64'(match_o), 64'h2);
        pc = 64'h2000;
        settle();
        check("R12", "only bp0", 64'(match_o), 64'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule